// File: doc/BRIEF.md
# Nibble-Serial CRC Accumulator

This block keeps a 16-bit cyclic redundancy check that advances by one whole 4-bit nibble per clock instead of one bit. Each nibble that passes the checksummed fetch stream is folded in with a shift right by four. The folded value is the low four bits of the register XOR the nibble, multiplied by 0x1081, and that product is XORed in. When a fetch hits an address window that is switched off, the fetch is flagged as blank and a zero nibble is folded in instead of the data.

Software sees the register as four nibble slices. Index 0 holds bits 3:0 and index 3 holds bits 15:12. A side write port replaces one slice. A plain read port returns one slice and never disturbs the register.

The fetch stream uses valid/ready. `in_ready` is low while a slice write is applied and during reset. A producer holds `in_nib` and `in_blank` steady with `in_valid` high until it sees ready. No nibble is lost when a write collides with the stream: the write takes the cycle and the nibble is accepted on a later one.

Top module: `crc_nib_accum`

## Requirements
- R1: On each accepted nibble (`in_valid` and `in_ready` both high at a rising edge), the register becomes (crc >> 4) XOR (((crc XOR nib) & 0xF) * 0x1081), truncated to 16 bits. For example, 0x0000 with nibble 1 gives 0x1081, and a following nibble 0 gives 0x1189.
- R2: After an accepted nibble, bits 15:12 of the register equal the low nibble of the previous value XOR the folded nibble.
- R3: `rd_nib` returns bits [4*rd_idx+3 : 4*rd_idx] of the current register, combinationally, where index 0 is bits 3:0.
- R4: A write with `wr_en` high replaces only the slice selected by `wr_idx` with `wr_nib`. The new slice is visible from the next cycle, and the other three slices keep their values.
- R5: Changing `rd_idx` or reading any slice never changes the register.
- R6: An accepted nibble with `in_blank` high folds in 0, whatever `in_nib` holds.
- R7: While `wr_en` is high, `in_ready` is low, so a write and a fetch in the same cycle apply the write and leave the nibble pending.
- R8: Synchronous active-high `rst` clears the register to 0x0000 and holds `in_ready` low. Reset takes priority over a write.
- R9: With no accepted nibble and no write, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch stream nibble valid |
| in_ready | output | 1 | Fetch stream nibble accepted when high with valid |
| in_nib | input | 4 | Fetched data nibble |
| in_blank | input | 1 | Fetch came from a disabled window; fold zero |
| wr_en | input | 1 | Slice write strobe |
| wr_idx | input | 2 | Slice index for writes |
| wr_nib | input | 4 | Slice write data |
| rd_idx | input | 2 | Slice index for plain reads |
| rd_nib | output | 4 | Selected slice of the register |
| crc_out | output | 16 | Whole register value |

## Verification
A wrong register value shows on `crc_out` in the cycle after the edge that caused it. It reaches `rd_nib` as soon as the bench selects the affected slice. Because the fold feeds every later step, a single bad step makes every later value differ as well. The bench compares both outputs and `in_ready` against a behavioural model on every clock. It also walks `rd_idx` over all four slices so that a slice-order fault is caught within four cycles.

// File: rtl/crc_nib_pkg.sv
package crc_nib_pkg;
  localparam int unsigned CRC_W   = 16;
  localparam int unsigned NIB_W   = 4;
  localparam int unsigned N_TAPS  = 3;
  // Left shifts that together make the constant multiplier 0x1081
  localparam int unsigned CRC_TAPS [N_TAPS] = '{0, 7, 12};
endpackage

// File: rtl/crc_nib_step.sv
module crc_nib_step
  import crc_nib_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned NW = NIB_W
) (
  input  logic [W-1:0]  cur,
  input  logic [NW-1:0] nib,
  output logic [W-1:0]  nxt
);
  logic [NW-1:0] fold_d;
  logic [W-1:0]  term [N_TAPS];
  logic [W-1:0]  prod;

  assign fold_d = cur[NW-1:0] ^ nib;

  for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
    assign term[t] = W'({{(W-NW){1'b0}}, fold_d} << CRC_TAPS[t]);
  end

  always_comb begin
    prod = '0;
    for (int t = 0; t < N_TAPS; t++) prod = prod ^ term[t];
  end

  assign nxt = (cur >> NW) ^ prod;
endmodule

// File: rtl/crc_nib_slice_mux.sv
module crc_nib_slice_mux
  import crc_nib_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned NW = NIB_W,
  localparam int unsigned NS = W / NW,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [W-1:0]  word,
  input  logic [IW-1:0] idx,
  output logic [NW-1:0] slice
);
  logic [NW-1:0] parts [NS];
  for (genvar s = 0; s < NS; s++) begin : g_part
    assign parts[s] = word[s*NW +: NW];
  end
  assign slice = parts[idx];
endmodule

// File: rtl/crc_nib_accum.sv
module crc_nib_accum
  import crc_nib_pkg::*;
#(
  parameter int unsigned W  = CRC_W,
  parameter int unsigned NW = NIB_W,
  localparam int unsigned NS = W / NW,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [NW-1:0] in_nib,
  input  logic          in_blank,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [NW-1:0] wr_nib,
  input  logic [IW-1:0] rd_idx,
  output logic [NW-1:0] rd_nib,
  output logic [W-1:0]  crc_out
);
  logic [W-1:0]  crc_q;
  logic [W-1:0]  crc_step;
  logic [NW-1:0] fold_nib;
  logic          accept;

  // The slice write owns the cycle; the stream waits
  assign in_ready = ~rst & ~wr_en;
  assign accept   = in_valid & in_ready;
  assign fold_nib = in_blank ? '0 : in_nib;

  crc_nib_step #(.W(W), .NW(NW)) u_step (
    .cur (crc_q),
    .nib (fold_nib),
    .nxt (crc_step)
  );

  for (genvar s = 0; s < NS; s++) begin : g_slice
    always_ff @(posedge clk) begin
      if (rst)
        crc_q[s*NW +: NW] <= '0;
      else if (wr_en) begin
        if (wr_idx == IW'(s)) crc_q[s*NW +: NW] <= wr_nib;
      end else if (accept)
        crc_q[s*NW +: NW] <= crc_step[s*NW +: NW];
    end
  end

  crc_nib_slice_mux #(.W(W), .NW(NW)) u_rdmux (
    .word  (crc_q),
    .idx   (rd_idx),
    .slice (rd_nib)
  );

  assign crc_out = crc_q;
endmodule

// File: rtl/crc_nib_accum_chk.sv
module crc_nib_accum_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned NW = 4,
  localparam int unsigned NS = W / NW,
  localparam int unsigned IW = (NS > 1) ? $clog2(NS) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic [NW-1:0] in_nib,
  input logic          in_blank,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [NW-1:0] wr_nib,
  input logic [W-1:0]  crc_out
);
  logic          acc;
  logic [NW-1:0] eff_nib;
  logic          seen_clk;
  assign acc     = in_valid & in_ready;
  assign eff_nib = in_blank ? '0 : in_nib;

  initial seen_clk = 1'b0;
  always @(posedge clk) seen_clk <= 1'b1;

  function automatic logic [W-1:0] keep_mask(input logic [IW-1:0] i);
    return ~(W'({NW{1'b1}}) << (NW * i));
  endfunction

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> crc_out == '0);

  assert_ready_low_in_reset_R8: assert property (@(posedge clk)
    seen_clk && rst |-> !in_ready);

  assert_write_blocks_stream_R7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !in_ready);

  assert_write_slice_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((crc_out >> (NW * $past(wr_idx))) & W'({NW{1'b1}})) == W'($past(wr_nib)));

  assert_write_others_kept_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((crc_out ^ $past(crc_out)) & keep_mask($past(wr_idx))) == '0);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !acc |=> $stable(crc_out));

  assert_top_nibble_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> crc_out[W-1 -: NW] == ($past(crc_out[NW-1:0]) ^ $past(eff_nib)));

  assert_blank_folds_zero_R6: assert property (@(posedge clk) disable iff (rst)
    acc && in_blank |=> crc_out[W-1 -: NW] == $past(crc_out[NW-1:0]));
endmodule

bind crc_nib_accum crc_nib_accum_chk #(.W(W), .NW(NW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_nib   (in_nib),
  .in_blank (in_blank),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_nib   (wr_nib),
  .crc_out  (crc_out)
);

// File: tb/crc_nib_accum_tb.sv
module crc_nib_accum_tb;
  logic       clk = 1'b0;
  logic       rst, in_valid, in_blank, wr_en;
  logic [3:0] in_nib, wr_nib, rd_nib;
  logic [1:0] wr_idx, rd_idx;
  logic       in_ready;
  logic [15:0] crc_out;

  int vectors = 0;
  int miscompares = 0;
  int model = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crc_nib_accum u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_nib(in_nib), .in_blank(in_blank), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_nib(wr_nib), .rd_idx(rd_idx), .rd_nib(rd_nib), .crc_out(crc_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, check ready, advance model, check state
  task automatic cyc(input bit r, input bit v, input int n, input bit b,
                     input bit we, input int wi, input int wn, input int ri,
                     input string tag);
    int d;
    bit rdy;
    rst = r; in_valid = v; in_nib = 4'(n); in_blank = b;
    wr_en = we; wr_idx = 2'(wi); wr_nib = 4'(wn); rd_idx = 2'(ri);
    #1;
    rdy = !r && !we;
    chk({tag, " R7 ready"}, int'(in_ready), int'(rdy));
    chk({tag, " R3 read"}, int'(rd_nib), (model >> (4*ri)) & 15);
    @(posedge clk);
    if (r) model = 0;
    else if (we) model = (model & ~(15 << (4*wi))) | ((wn & 15) << (4*wi));
    else if (v && rdy) begin
      d = (model ^ (b ? 0 : n)) & 15;
      model = ((model >> 4) ^ (d * 'h1081)) & 'hFFFF;
    end
    @(negedge clk);
    chk({tag, " value"}, int'(crc_out), model);
  endtask

  initial begin
    rst = 1; in_valid = 0; in_nib = 0; in_blank = 0;
    wr_en = 0; wr_idx = 0; wr_nib = 0; rd_idx = 0;
    @(negedge clk);
    cyc(1, 0, 0, 0, 1, 2, 9, 0, "R8 reset");
    chk("R8 reset zero", int'(crc_out), 0);
    // R1 known vector
    cyc(0, 1, 1, 0, 0, 0, 0, 0, "R1 nib1");
    chk("R1 after 1", int'(crc_out), 'h1081);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R1 nib0");
    chk("R1 after 0", int'(crc_out), 'h1189);
    // R3/R5 plain reads on every slice leave value
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0, i, "R5 readwalk");
    chk("R5 unchanged", int'(crc_out), 'h1189);
    // R4 slice writes
    cyc(0, 0, 0, 0, 1, 0, 'hA, 0, "R4 w0");
    cyc(0, 0, 0, 0, 1, 3, 'h5, 3, "R4 w3");
    chk("R4 slices", int'(crc_out), 'h518A);
    cyc(0, 0, 0, 0, 1, 1, 'hF, 1, "R4 w1");
    cyc(0, 0, 0, 0, 1, 2, 'h0, 2, "R4 w2");
    chk("R4 slices2", int'(crc_out), 'h50FA);
    // R6 blank folds zero, data ignored
    cyc(0, 1, 'hD, 1, 0, 0, 0, 3, "R6 blank");
    chk("R6 top nibble", int'(crc_out[15:12]), 'hA);
    // R7 collision: write wins, nibble held then accepted
    cyc(0, 1, 7, 0, 1, 1, 3, 0, "R7 collide");
    cyc(0, 1, 7, 0, 0, 0, 0, 0, "R7 retry");
    // R9 idle hold with valid low but data wiggling
    cyc(0, 0, 'hE, 0, 0, 0, 0, 2, "R9 idle");
    // R8 reset beats write
    cyc(1, 1, 3, 0, 1, 0, 'hF, 0, "R8 rst-vs-wr");
    chk("R8 clear", int'(crc_out), 0);
    // R1/R2 mixed pattern, many steps
    for (int k = 0; k < 300; k++)
      cyc(0, (k % 5) != 0, (k * 7 + 3) & 15, (k % 11) == 0,
          (k % 13) == 6, k & 3, (k * 3) & 15, (k >> 1) & 3, "R1 R2 mix");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule